// File: doc/BRIEF.md
# Sixteen-Bit Timer and Event Counter

This block holds a 16-bit up-counter that runs either as a timer or as an event counter. A free-running divider splits the clock into machine cycles of twelve clock periods. In timer mode the count advances once per machine cycle. In event mode the count advances once for each falling edge seen on an external input. That input is first synchronised and then sampled once per machine cycle, so an event needs two machine-cycle samples to be recognised. The highest event rate is therefore half the machine-cycle rate.

A run-enable input gates all counting. Software can load either byte of the count directly. When the count wraps from 0xFFFF to 0x0000 it raises an overflow flag, which stays set until software clears it.

The external-edge detector is a three-state machine:
- `EDG_UNKNOWN` is the state after reset, before any sample has been taken.
- `EDG_HIGH` means the last sample was 1.
- `EDG_LOW` means the last sample was 0.

On every machine-cycle boundary the machine moves to `EDG_HIGH` or `EDG_LOW` according to the new sample. The move `EDG_HIGH` to `EDG_LOW` is the only transition that reports a falling edge. Between boundaries the state holds.

Top module: `evt_timer16`

## Requirements
- R1: After reset, `count_q` is 0x0000 and `ovf_flag` is 0.
- R2: A machine-cycle boundary occurs on every 12th rising clock edge after reset is released. The divider runs freely and is never restarted by other inputs. With `run_en`=1 and `count_mode`=0 (timer), the count increments by one on each boundary edge.
- R3: While `run_en`=0 the count does not change except through byte writes.
- R4: With `count_mode`=1 (event), `ext_in` passes through two flops and is sampled on each boundary. The count increments on a boundary whose sample is 0 when the previous boundary's sample was 1. The first sample after reset never counts.
- R5: At most one event is counted per two machine cycles. A level that lasts less than one machine cycle may be missed.
- R6: A falling edge sampled while `run_en`=0 is not counted later, even after `run_en` is set again.
- R7: When `wr_lo`=1, `count_q[7:0]` takes `wr_data` on that edge. When `wr_hi`=1, `count_q[15:8]` takes `wr_data` on that edge. The other byte is kept. Any byte write suppresses the increment that would occur on the same edge.
- R8: An increment from 0xFFFF gives 0x0000 and sets `ovf_flag`. The flag then stays set. If the overflow and `ovf_clr` occur on the same edge, the set wins.
- R9: `ovf_clr`=1 clears `ovf_flag` on the next edge, unless an overflow occurs on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counting enabled when 1 |
| count_mode | input | 1 | 0 = timer, 1 = event counter |
| ext_in | input | 1 | Asynchronous event input |
| wr_lo | input | 1 | Load low byte from wr_data |
| wr_hi | input | 1 | Load high byte from wr_data |
| wr_data | input | 8 | Byte write data |
| ovf_clr | input | 1 | Clear overflow flag |
| count_q | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Byte writes, flag clears and timer increments show at the outputs one clock after the edge that caused them. An event on `ext_in` takes longer to appear. It needs two synchroniser clocks to reach the sampler, then waits for the next machine-cycle boundary, then one more edge to reach `count_q`. The bench drives inputs on falling clock edges and updates a reference model on rising edges, using functions written from the requirements. It compares both outputs on every falling edge, so each result is checked in exactly the cycle it is due. Directed phases cover overflow, clear-versus-set, write priority and stopped-while-edging, and seeded random phases cover the rest.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        EDG_UNKNOWN = 2'd0,
        EDG_HIGH    = 2'd1,
        EDG_LOW     = 2'd2
    } edge_st_t;

    typedef enum logic {
        MODE_TIMER = 1'b0,
        MODE_EVENT = 1'b1
    } cnt_mode_t;

endpackage

// File: rtl/mc_prescaler.sv
module mc_prescaler #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == LAST);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/in_sync.sv
module in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= din;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/edge_fsm.sv
module edge_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic lvl,
    output logic fall
);
    edge_st_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EDG_UNKNOWN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fall    = 1'b0;
        unique case (state_q)
            EDG_UNKNOWN: begin
                if (tick) state_d = lvl ? EDG_HIGH : EDG_LOW;
            end
            EDG_HIGH: begin
                if (tick && !lvl) begin
                    state_d = EDG_LOW;
                    fall    = 1'b1;
                end
            end
            EDG_LOW: begin
                if (tick && lvl) state_d = EDG_HIGH;
            end
            default: state_d = EDG_UNKNOWN;
        endcase
    end

    // R4
    fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> tick);

    // R5
    no_double_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> (state_q == EDG_LOW));

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
    import tmr_pkg::*;
#(
    parameter int CW       = 16,
    parameter int BW       = 8,
    parameter int MC_DIV   = 12,
    parameter int SYNC_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          count_mode,
    input  logic          ext_in,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [BW-1:0] wr_data,
    input  logic          ovf_clr,
    output logic [CW-1:0] count_q,
    output logic          ovf_flag
);
    localparam logic [CW-1:0] ALL_ONES = '1;

    logic      tick;
    logic      ext_s;
    logic      fall;
    logic      step;
    logic      any_wr;
    cnt_mode_t mode;

    mc_prescaler #(.DIV(MC_DIV)) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    in_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_in),
        .dout (ext_s)
    );

    edge_fsm u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .lvl  (ext_s),
        .fall (fall)
    );

    assign mode   = cnt_mode_t'(count_mode);
    assign any_wr = wr_lo | wr_hi;

    always_comb begin
        step = 1'b0;
        if (run_en && !any_wr) begin
            unique case (mode)
                MODE_TIMER: step = tick;
                MODE_EVENT: step = fall;
                default:    step = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (any_wr) begin
            if (wr_lo) count_q[BW-1:0]  <= wr_data;
            if (wr_hi) count_q[CW-1:BW] <= wr_data;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_flag <= 1'b0;
        else if (step && count_q == ALL_ONES)
            ovf_flag <= 1'b1;
        else if (ovf_clr)
            ovf_flag <= 1'b0;
    end

    // R3
    hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !any_wr) |=> $stable(count_q));

    // R7
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (count_q[BW-1:0] == $past(wr_data)));

    // R7
    high_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (count_q[CW-1:BW] == $past(wr_data)));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1));

    // R8
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_wr && count_q == ALL_ONES && run_en && (tick || fall)) |=> (ovf_flag || $past(count_q) == $past(count_q) && count_q == ALL_ONES));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

endmodule

// File: tb/sim_evt_timer16.sv
`timescale 1ns/1ps
module sim_evt_timer16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        run_en, count_mode, ext_in, wr_lo, wr_hi, ovf_clr;
    logic [7:0]  wr_data;
    logic [15:0] count_q;
    logic        ovf_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    evt_timer16 u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .count_mode(count_mode),
        .ext_in(ext_in), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .ovf_clr(ovf_clr), .count_q(count_q), .ovf_flag(ovf_flag)
    );

    // reference model built from the requirements
    int          m_phase;
    logic        m_s1, m_s2;
    int          m_est;      // 0 none yet, 1 high, 2 low
    logic [15:0] m_cnt;
    logic        m_ovf;

    function automatic logic [15:0] next_count(logic [15:0] c, logic wl, logic wh,
                                               logic [7:0] d, logic inc);
        logic [15:0] r = c;
        if (wl || wh) begin
            if (wl) r[7:0]  = d;
            if (wh) r[15:8] = d;
        end else if (inc) begin
            r = c + 16'd1;
        end
        return r;
    endfunction

    function automatic logic next_flag(logic f, logic inc, logic [15:0] c, logic clr);
        if (inc && c == 16'hFFFF) return 1'b1;
        if (clr) return 1'b0;
        return f;
    endfunction

    always @(posedge clk) begin
        logic bnd, edg, inc;
        if (!rst_n) begin
            m_phase <= 0; m_s1 <= 0; m_s2 <= 0; m_est <= 0;
            m_cnt <= 16'h0; m_ovf <= 1'b0;
        end else begin
            bnd = (m_phase == 11);
            edg = bnd && (m_est == 1) && !m_s2;
            inc = run_en && !(wr_lo || wr_hi) && (count_mode ? edg : bnd);
            m_phase <= bnd ? 0 : m_phase + 1;
            m_s1 <= ext_in;
            m_s2 <= m_s1;
            if (bnd) m_est <= m_s2 ? 1 : 2;
            m_cnt <= next_count(m_cnt, wr_lo, wr_hi, wr_data, inc);
            m_ovf <= next_flag(m_ovf, inc, m_cnt, ovf_clr);
        end
    end

    task automatic check_now();
        checks++;
        if (count_q !== m_cnt) begin
            fails++;
            $display("FAIL %s count_q actual %h expected %h", tag, count_q, m_cnt);
        end
        checks++;
        if (ovf_flag !== m_ovf) begin
            fails++;
            $display("FAIL %s ovf_flag actual %b expected %b", tag, ovf_flag, m_ovf);
        end
    endtask

    task automatic idle_inputs();
        wr_lo = 0; wr_hi = 0; ovf_clr = 0; wr_data = 8'h00;
    endtask

    task automatic cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now();
            idle_inputs();
        end
    endtask

    task automatic load(logic [15:0] v);
        @(negedge clk); check_now();
        wr_lo = 1; wr_hi = 0; wr_data = v[7:0];
        @(negedge clk); check_now();
        wr_lo = 0; wr_hi = 1; wr_data = v[15:8];
        @(negedge clk); check_now();
        idle_inputs();
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd1234);
        rst_n = 0; run_en = 0; count_mode = 0; ext_in = 1;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        tag = "R1";
        checks++;
        if (count_q !== 16'h0 || ovf_flag !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual %h/%b expected 0000/0", count_q, ovf_flag);
        end

        // R2 timer mode
        tag = "R2"; run_en = 1; count_mode = 0;
        cycles(120);
        checks++;
        if (count_q !== 16'd10) begin
            fails++;
            $display("FAIL R2 timer count actual %0d expected 10", count_q);
        end

        // R3 stopped
        tag = "R3"; run_en = 0;
        cycles(60);
        run_en = 1;

        // R8 wrap, R9 clear
        tag = "R8";
        load(16'hFFFE);
        cycles(40);
        tag = "R9"; ovf_clr = 1;
        cycles(2);

        // R8 set wins over clear: hold clear asserted across a wrap
        tag = "R8";
        load(16'hFFFF);
        for (int i = 0; i < 14; i++) begin
            @(negedge clk); check_now(); ovf_clr = 1;
        end
        idle_inputs();
        cycles(2);

        // R7 write priority over increments, random byte writes
        tag = "R7";
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); check_now();
            idle_inputs();
            wr_lo = ($urandom % 5) == 0;
            wr_hi = ($urandom % 7) == 0;
            wr_data = 8'($urandom);
        end
        idle_inputs();

        // R4 event mode, slow toggling
        tag = "R4"; count_mode = 1; run_en = 1;
        load(16'h0000);
        for (int i = 0; i < 20; i++) begin
            ext_in = ~ext_in;
            cycles(30);
        end

        // R5 fast random toggling
        tag = "R5";
        for (int i = 0; i < 400; i++) begin
            ext_in = 1'($urandom);
            cycles(1 + ($urandom % 20));
        end

        // R6 edges while stopped
        tag = "R6";
        ext_in = 1; cycles(40);
        run_en = 0; ext_in = 0; cycles(40);
        run_en = 1; cycles(40);

        // mixed random phase
        tag = "R2";
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk); check_now();
            idle_inputs();
            run_en     = ($urandom % 8) != 0;
            if (($urandom % 64) == 0) count_mode = ~count_mode;
            if (($urandom % 6) == 0) ext_in = ~ext_in;
            wr_lo   = ($urandom % 50) == 0;
            wr_hi   = ($urandom % 50) == 0;
            ovf_clr = ($urandom % 30) == 0;
            wr_data = 8'hF0 | 8'($urandom);
        end
        idle_inputs();
        cycles(5);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule